// File: doc/BRIEF.md
# Trigger-Driven Timer Counter

This block is an up/down counter meant to serve as a general-purpose timer inside a larger chip. A three-bit slave-mode field decides where its count clock, start, stop and restart come from. The source can be the system clock, either of two timer inputs read as a quadrature pair, or one of four trigger lines picked by a select field. Each count request first passes through a programmable prescaler. The count then runs between zero and an auto-reload limit, and it emits a one-cycle update pulse each time it wraps.

Software reaches the block through a plain write port with three registers: control, prescaler and reload. The prescaler value only takes effect at an update event. The reload value takes effect either at once or at the next update event, depending on a preload flag. Setting the update-generation bit in a control write forces an update at once: the counter restarts, the prescaler phase is cleared, and both buffered values are loaded.

All timer and trigger inputs are asynchronous. Each one passes through a two-flop synchronizer, and edges are detected in the system clock domain.

Top module: `tmr_slave_counter`

## Requirements
- R1: After synchronous reset the count is 0, the counter is disabled, the update pulse is low and the direction output is 0 (up).
- R2: The write port decodes wr_addr 0 = control, 1 = prescaler, 2 = reload. Control bits are: bit 0 run, bit 1 reload preload, bit 2 count down, bits 5:3 slave mode, bits 7:6 trigger select, bit 8 update generation (a strobe, not stored).
- R3: With prescaler value P, the counter moves once per P+1 accepted count requests. A new P is used only from the next update event.
- R4: Counting up, the step from the reload value goes to 0. Counting down, the step from 0 goes to the reload value. Either wrap raises upd_evt for exactly one cycle, starting with the cycle that shows the wrapped count.
- R5: With preload set, a reload write takes effect only at the next update event. With preload clear, it takes effect at once.
- R6: The update-generation strobe reloads the prescaler and reload values, clears the prescaler phase, and pulses upd_evt. It sets the count to 0, or to the reload value in non-encoder modes when the down bit is set.
- R7: Mode 0 (free): while run is set, every system clock cycle is a count request.
- R8: Mode 1: the counter steps on every TI2 edge. It counts up if TI1 equals TI2 after the edge, and down otherwise.
- R9: Mode 2: the counter steps on every TI1 edge. It counts up if TI1 differs from TI2 after the edge, and down otherwise. The direction output follows the last counted step in all encoder modes.
- R10: Mode 3: the counter steps on edges of either input, using the rule of R8 for TI2 edges and R9 for TI1 edges. It wraps and pulses upd_evt in both directions, and holds when neither input changes.
- R11: Mode 4 (restart): a rising edge of the selected trigger restarts the count as in R6, loads the buffered values and pulses upd_evt.
- R12: Mode 5 (gated): count requests occur only while the selected trigger is high. The count holds, and is not cleared, while the trigger is low.
- R13: Mode 6 (start): a rising edge of the selected trigger sets cnt_en without touching the count. A falling trigger does not stop it.
- R14: Mode 7 (external clock): each rising edge of the trigger picked by the select field (0..3 = trig_in bit) is one count request. Other trigger lines have no effect. An input change applied before clock edge k moves the count at edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ti1 | input | 1 | Timer input 1 (asynchronous) |
| ti2 | input | 1 | Timer input 2 (asynchronous) |
| trig_in | input | 4 | Trigger inputs (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Counter value |
| cnt_en | output | 1 | Counter enable state |
| upd_evt | output | 1 | One-cycle update event |
| dir_down | output | 1 | Current direction, 1 = down |

## Verification
The free-running mode is driven with prescaler values 2 and 0 and with a shrinking reload under preload. This separates a divide-by-P+1 prescaler from an off-by-one one, and a buffered reload from an immediate one. Each encoder mode is stepped through forward and reverse quadrature sequences. Only one input sequence is used, so the different step counts per mode show which edges each mode accepts, and the down wrap shows the reverse rule. The gated, start, restart and external-clock modes all get pulses on a trigger line other than the selected one as well as on the selected one. This tells an ignored trigger apart from an accepted one. The latency and hold behaviour of each of these modes is sampled on the exact cycle it should appear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TRIG_N = 4;
    localparam int TSEL_W = $clog2(TRIG_N);

    typedef enum logic [2:0] {
        SM_FREE     = 3'd0,
        SM_ENC_T2   = 3'd1,
        SM_ENC_T1   = 3'd2,
        SM_ENC_BOTH = 3'd3,
        SM_RESTART  = 3'd4,
        SM_GATE     = 3'd5,
        SM_START    = 3'd6,
        SM_EXTCLK   = 3'd7
    } slave_mode_e;

    typedef enum logic [1:0] {
        RA_CTRL   = 2'd0,
        RA_PSC    = 2'd1,
        RA_RELOAD = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    localparam int CTL_RUN      = 0;
    localparam int CTL_PRE      = 1;
    localparam int CTL_DOWN     = 2;
    localparam int CTL_MODE_LSB = 3;
    localparam int CTL_TSEL_LSB = 6;
    localparam int CTL_UG       = 8;

    typedef struct packed {
        logic [TSEL_W-1:0] tsel;
        slave_mode_e       mode;
        logic              down;
        logic              preload;
    } cfg_t;

    typedef struct packed {
        logic tick;      // one count request this cycle (before prescaler)
        logic enc_down;  // direction of an encoder step
        logic restart;   // restart event from trigger
        logic start_set; // set enable from trigger
    } slave_req_t;

    function automatic logic is_encoder(slave_mode_e m);
        return (m == SM_ENC_T2) || (m == SM_ENC_T1) || (m == SM_ENC_BOTH);
    endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [2:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[1:0], din[i]};
            end
            assign lvl[i]      = sh[1];
            assign lvl_prev[i] = sh[2];
        end
    endgenerate
endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
    import tmr_pkg::*;
(
    input  slave_mode_e        mode,
    input  logic [TSEL_W-1:0]  tsel,
    input  logic [1:0]         ti_lvl,
    input  logic [1:0]         ti_prev,
    input  logic [TRIG_N-1:0]  trg_lvl,
    input  logic [TRIG_N-1:0]  trg_prev,
    output slave_req_t         req
);
    logic t1_chg, t2_chg, same, trg_hi, trg_rise;

    assign t1_chg   = ti_lvl[0] ^ ti_prev[0];
    assign t2_chg   = ti_lvl[1] ^ ti_prev[1];
    assign same     = (ti_lvl[0] == ti_lvl[1]);
    assign trg_hi   = trg_lvl[tsel];
    assign trg_rise = trg_lvl[tsel] & ~trg_prev[tsel];

    always_comb begin
        req = '0;
        unique case (mode)
            SM_FREE, SM_RESTART, SM_START: req.tick = 1'b1;
            SM_GATE:   req.tick = trg_hi;
            SM_EXTCLK: req.tick = trg_rise;
            SM_ENC_T2: begin
                req.tick     = t2_chg;
                req.enc_down = ~same;
            end
            SM_ENC_T1: begin
                req.tick     = t1_chg;
                req.enc_down = same;
            end
            SM_ENC_BOTH: begin
                // simultaneous change of both inputs is not a valid step
                req.tick     = t1_chg ^ t2_chg;
                req.enc_down = t1_chg ? same : ~same;
            end
            default: req.tick = 1'b0;
        endcase
        req.restart   = (mode == SM_RESTART) && trg_rise;
        req.start_set = (mode == SM_START) && trg_rise;
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_in,
    input  logic             clear,
    input  logic             load,
    input  logic [PSC_W-1:0] psc_new,
    output logic             cnt_tick
);
    logic [PSC_W-1:0] phase_q, div_q;

    assign cnt_tick = tick_in && (phase_q == div_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            div_q   <= '0;
        end else begin
            if (clear)        phase_q <= '0;
            else if (tick_in) phase_q <= cnt_tick ? '0 : phase_q + 1'b1;
            if (load)         div_q   <= psc_new;
        end
    end

    AST_PSC_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        phase_q <= div_q); // R3
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             down,
    input  logic             reinit,
    input  logic [CNT_W-1:0] reinit_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic at_edge;

    assign at_edge = down ? (count == '0) : (count == reload);
    assign wrap    = step && !reinit && at_edge;

    always_ff @(posedge clk) begin
        if (rst)              count <= '0;
        else if (reinit)      count <= reinit_val;
        else if (step) begin
            if (down) count <= at_edge ? reload : count - 1'b1;
            else      count <= at_edge ? '0     : count + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_slave_counter.sv
module tmr_slave_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ti1,
    input  logic              ti2,
    input  logic [TRIG_N-1:0] trig_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              cnt_en,
    output logic              upd_evt,
    output logic              dir_down
);
    cfg_t              cfg_q, cfg_nxt;
    logic              run_q, enc_dir_q, upd_q;
    logic [PSC_W-1:0]  psc_pre, psc_src;
    logic [CNT_W-1:0]  arr_pre, arr_act, arr_src, reinit_val;
    logic [1:0]        ti_lvl, ti_prev;
    logic [TRIG_N-1:0] trg_lvl, trg_prev;
    slave_req_t        req;
    logic              wr_ctl, wr_psc, wr_arr, ug, reinit, wrap, cnt_tick, step_down, upd;

    tmr_sync_edge #(.W(2)) i_ti_sync (
        .clk(clk), .rst(rst), .din({ti2, ti1}), .lvl(ti_lvl), .lvl_prev(ti_prev));

    tmr_sync_edge #(.W(TRIG_N)) i_trg_sync (
        .clk(clk), .rst(rst), .din(trig_in), .lvl(trg_lvl), .lvl_prev(trg_prev));

    tmr_slave_ctrl i_slave (
        .mode(cfg_q.mode), .tsel(cfg_q.tsel), .ti_lvl(ti_lvl), .ti_prev(ti_prev),
        .trg_lvl(trg_lvl), .trg_prev(trg_prev), .req(req));

    assign wr_ctl = wr_en && (wr_addr == RA_CTRL);
    assign wr_psc = wr_en && (wr_addr == RA_PSC);
    assign wr_arr = wr_en && (wr_addr == RA_RELOAD);
    assign ug     = wr_ctl && wr_data[CTL_UG];
    assign reinit = ug || req.restart;
    assign upd    = reinit || wrap;

    always_comb begin
        cfg_nxt = cfg_q;
        if (wr_ctl) begin
            cfg_nxt.preload = wr_data[CTL_PRE];
            cfg_nxt.down    = wr_data[CTL_DOWN];
            cfg_nxt.mode    = slave_mode_e'(wr_data[CTL_MODE_LSB +: 3]);
            cfg_nxt.tsel    = wr_data[CTL_TSEL_LSB +: TSEL_W];
        end
    end

    assign arr_src = wr_arr ? wr_data : arr_pre;
    assign psc_src = wr_psc ? wr_data[PSC_W-1:0] : psc_pre;

    always_comb begin
        reinit_val = '0;
        if (!is_encoder(cfg_nxt.mode) && cfg_nxt.down) reinit_val = arr_src;
    end

    assign step_down = is_encoder(cfg_q.mode) ? req.enc_down : cfg_q.down;

    tmr_prescaler #(.PSC_W(PSC_W)) i_psc (
        .clk(clk), .rst(rst), .tick_in(run_q && req.tick), .clear(reinit),
        .load(upd), .psc_new(psc_src), .cnt_tick(cnt_tick));

    tmr_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst(rst), .step(cnt_tick), .down(step_down), .reinit(reinit),
        .reinit_val(reinit_val), .reload(arr_act), .count(count), .wrap(wrap));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '{tsel: '0, mode: SM_FREE, down: 1'b0, preload: 1'b0};
            run_q     <= 1'b0;
            psc_pre   <= '0;
            arr_pre   <= '0;
            arr_act   <= '0;
            enc_dir_q <= 1'b0;
            upd_q     <= 1'b0;
        end else begin
            cfg_q <= cfg_nxt;
            upd_q <= upd;
            if (wr_ctl)              run_q <= wr_data[CTL_RUN];
            else if (req.start_set)  run_q <= 1'b1;
            if (wr_psc) psc_pre <= wr_data[PSC_W-1:0];
            if (wr_arr) arr_pre <= wr_data;
            if (upd)                          arr_act <= arr_src;
            else if (wr_arr && !cfg_q.preload) arr_act <= wr_data;
            if (run_q && req.tick && is_encoder(cfg_q.mode)) enc_dir_q <= req.enc_down;
        end
    end

    assign cnt_en   = run_q;
    assign upd_evt  = upd_q;
    assign dir_down = is_encoder(cfg_q.mode) ? enc_dir_q : cfg_q.down;

    AST_UPD_UP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (upd_evt && !dir_down && $stable(dir_down)) |-> (count == '0)); // R4

    AST_GATE_LOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == SM_GATE && !trg_lvl[cfg_q.tsel] && !wr_ctl) |=> $stable(count)); // R12

    AST_EXT_NO_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == SM_EXTCLK && !(trg_lvl[cfg_q.tsel] && !trg_prev[cfg_q.tsel]) && !ug)
        |=> $stable(count)); // R14

    AST_START_SETS_EN: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == SM_START && trg_lvl[cfg_q.tsel] && !trg_prev[cfg_q.tsel] && !wr_ctl)
        |=> cnt_en); // R13

    AST_ENC_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (is_encoder(cfg_q.mode) && (ti_lvl == ti_prev) && !ug) |=> $stable(count)); // R10
endmodule

// File: tb/test_tmr_slave_counter.sv
`timescale 1ns/1ps
module test_tmr_slave_counter;
    localparam int CNT_W = 16;
    localparam time HALF = 2.5ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ti1 = 1'b0, ti2 = 1'b0;
    logic [3:0] trig_in = '0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] count;
    logic cnt_en, upd_evt, dir_down;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int enc_idx = 0;

    typedef struct {
        int    kind;   // 0 count, 1 upd_evt, 2 cnt_en, 3 dir_down
        int    exp;
        string req;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #HALF clk = ~clk;

    tmr_slave_counter #(.CNT_W(CNT_W), .PSC_W(16)) i_tmr_slave_counter (
        .clk(clk), .rst(rst), .ti1(ti1), .ti2(ti2), .trig_in(trig_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count(count), .cnt_en(cnt_en), .upd_evt(upd_evt), .dir_down(dir_down));

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            #1ns;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                int act;
                string nm;
                it = sb_q.pop_front();
                case (it.kind)
                    0: begin act = int'(count); nm = "count"; end
                    1: begin act = int'(upd_evt); nm = "upd_evt"; end
                    2: begin act = int'(cnt_en); nm = "cnt_en"; end
                    default: begin act = int'(dir_down); nm = "dir_down"; end
                endcase
                checks++;
                if (act != it.exp) begin
                    errors++;
                    $display("FAIL %s %s: actual %0d expected %0d at %0t", it.req, nm, act, it.exp, $time);
                end
            end
        end
    end

    task automatic expect_val(input int kind, input int exp, input string req);
        sb_item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic settle();
        wait (sb_q.size() == 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [CNT_W-1:0] ctl(input int run, input int pre, input int down,
                                             input int mode, input int tsel, input int ug);
        int v;
        v = run | (pre << 1) | (down << 2) | (mode << 3) | (tsel << 6) | (ug << 8);
        return CNT_W'(v);
    endfunction

    task automatic enc_step(input int fwd);
        enc_idx = fwd ? (enc_idx + 1) % 4 : (enc_idx + 3) % 4;
        ti1 = (enc_idx == 1) || (enc_idx == 2);
        ti2 = (enc_idx == 2) || (enc_idx == 3);
        idle(3);
    endtask

    task automatic pulse_trig(input int bitn, input int n);
        repeat (n) begin
            trig_in[bitn] = 1'b1; idle(2);
            trig_in[bitn] = 1'b0; idle(2);
        end
    endtask

    initial begin
        #(200000 * 2 * HALF);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(3);
        // R1 reset state, nothing moves while run is clear
        expect_val(0, 0, "R1"); expect_val(2, 0, "R1");
        expect_val(1, 0, "R1"); expect_val(3, 0, "R1"); settle();

        // R2 R3 R6 R7: free mode, prescaler 2
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd100);
        wr(2'd0, ctl(1, 0, 0, 0, 0, 1));
        expect_val(1, 1, "R6"); expect_val(0, 0, "R6"); expect_val(2, 1, "R2"); settle();
        idle(3); expect_val(0, 1, "R3"); settle();
        idle(3); expect_val(0, 2, "R7"); settle();

        // R4 up wrap with reload 3, prescaler 0
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd3);
        wr(2'd0, ctl(1, 0, 0, 0, 0, 1));
        idle(3); expect_val(0, 3, "R4"); expect_val(1, 0, "R4"); settle();
        idle(1); expect_val(0, 0, "R4"); expect_val(1, 1, "R4"); settle();
        idle(1); expect_val(0, 1, "R4"); expect_val(1, 0, "R4"); settle();

        // R5 preload: new reload waits for the update event
        wr(2'd0, ctl(0, 1, 0, 0, 0, 1));
        wr(2'd2, 16'd6);
        wr(2'd0, ctl(1, 1, 0, 0, 0, 0));
        idle(3); expect_val(0, 3, "R5"); settle();
        idle(1); expect_val(0, 0, "R5"); expect_val(1, 1, "R5"); settle();
        idle(6); expect_val(0, 6, "R5"); settle();
        idle(1); expect_val(0, 0, "R5"); expect_val(1, 1, "R5"); settle();

        // R4 R6 down counting restarts at reload
        wr(2'd0, ctl(0, 0, 1, 0, 0, 1));
        expect_val(0, 6, "R6"); expect_val(3, 1, "R4"); settle();
        wr(2'd0, ctl(1, 0, 1, 0, 0, 0));
        idle(6); expect_val(0, 0, "R4"); expect_val(1, 0, "R4"); settle();
        idle(1); expect_val(0, 6, "R4"); expect_val(1, 1, "R4"); settle();

        // R14 external clock on trigger 2, trigger 1 ignored
        wr(2'd2, 16'd100);
        wr(2'd0, ctl(1, 0, 0, 7, 2, 1));
        pulse_trig(1, 3);
        idle(2); expect_val(0, 0, "R14"); settle();
        pulse_trig(2, 3);
        idle(3); expect_val(0, 3, "R14"); settle();
        trig_in[2] = 1'b1;
        idle(2); expect_val(0, 3, "R14"); settle();
        idle(1); expect_val(0, 4, "R14"); settle();
        trig_in[2] = 1'b0; idle(3);

        // R12 gated on trigger 0
        wr(2'd0, ctl(1, 0, 0, 5, 0, 1));
        pulse_trig(1, 2);
        idle(1); expect_val(0, 0, "R12"); settle();
        trig_in[0] = 1'b1; idle(10);
        trig_in[0] = 1'b0; idle(5);
        expect_val(0, 10, "R12"); settle();
        idle(5); expect_val(0, 10, "R12"); settle();
        trig_in[0] = 1'b1; idle(4);
        trig_in[0] = 1'b0; idle(4);
        expect_val(0, 14, "R12"); settle();

        // R13 start on trigger 3
        wr(2'd0, ctl(0, 0, 0, 6, 3, 1));
        pulse_trig(0, 1);
        expect_val(0, 0, "R13"); expect_val(2, 0, "R13"); settle();
        trig_in[3] = 1'b1; idle(1);
        trig_in[3] = 1'b0; idle(2);
        expect_val(2, 1, "R13"); expect_val(0, 0, "R13"); settle();
        idle(5); expect_val(0, 5, "R13"); expect_val(2, 1, "R13"); settle();

        // R11 restart on trigger 1 loads a pending reload
        wr(2'd2, 16'd100);
        wr(2'd0, ctl(1, 1, 0, 4, 1, 1));
        wr(2'd2, 16'd5);
        pulse_trig(2, 1);
        idle(6); expect_val(0, 11, "R11"); settle();
        trig_in[1] = 1'b1;
        idle(2); expect_val(0, 13, "R11"); settle();
        idle(1); expect_val(0, 0, "R11"); expect_val(1, 1, "R11"); settle();
        trig_in[1] = 1'b0;
        idle(5); expect_val(0, 5, "R11"); settle();
        idle(1); expect_val(0, 0, "R11"); expect_val(1, 1, "R11"); settle();

        // R10 encoder on both inputs
        wr(2'd0, ctl(0, 0, 0, 3, 0, 0));
        wr(2'd2, 16'd99);
        wr(2'd0, ctl(1, 0, 0, 3, 0, 1));
        repeat (8) enc_step(1);
        expect_val(0, 8, "R10"); expect_val(3, 0, "R10"); settle();
        repeat (3) enc_step(0);
        expect_val(0, 5, "R10"); expect_val(3, 1, "R10"); settle();
        idle(4); expect_val(0, 5, "R10"); settle();
        wr(2'd0, ctl(1, 0, 0, 3, 0, 1));
        enc_step(0);
        expect_val(0, 99, "R10"); expect_val(1, 1, "R10"); expect_val(3, 1, "R10"); settle();
        enc_step(1);
        expect_val(0, 0, "R10"); expect_val(1, 1, "R10"); expect_val(3, 0, "R10"); settle();

        // R8 encoder on TI2 edges only
        wr(2'd0, ctl(1, 0, 0, 1, 0, 1));
        repeat (4) enc_step(1);
        expect_val(0, 2, "R8"); expect_val(3, 0, "R8"); settle();

        // R9 encoder on TI1 edges only, reverse through zero
        wr(2'd0, ctl(1, 0, 0, 2, 0, 1));
        repeat (4) enc_step(0);
        expect_val(0, 98, "R9"); expect_val(3, 1, "R9"); settle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule